// File: doc/BRIEF.md
# Byte-Wide Memory with Buffered Timekeeping Registers

This block puts a byte-wide memory behind a chip-enable, output-enable and write-enable bus, modelled synchronously on a single clock. The top eight addresses of the space do not reach the storage array. They open a window onto a bank of timekeeping registers: one control byte and seven BCD time bytes. The counting itself happens in a separate calendar block. That block supplies the live time and a one-cycle update strobe. It also accepts a load request when software has written a new time.

The seven time bytes seen on the bus are a shadow copy of the live counters. While the shadow is neither frozen nor open for writing, it follows the live time on every update strobe. Software can freeze the shadow to read a coherent snapshot. It can also open the shadow for writing and then commit it to the counters in one step. The counters never stop or wait for the bus. When the supply is reported out of tolerance, the block deselects itself and raises a power-fail flag.

`ADDR_W` sets the address width. A value of 15 gives the full 32K x 8 map with the clock window at 0x7FF8 to 0x7FFF. The default of 11 keeps the elaborated array small, and the window then sits at 0x7F8 to 0x7FF.

Top module: `tk_sram_rtc`

## Requirements
- R1: A read cycle is a cycle with ce_ni low, oe_ni low, we_ni high and pwr_ok_i high. The cycle after a read cycle has dq_oe_o high and rdata_o holding the addressed byte. After any other cycle, dq_oe_o is low and rdata_o is 0.
- R2: A write cycle is a cycle with ce_ni low, we_ni low and pwr_ok_i high. A write cycle to an address below the clock window stores wdata_i, and a later read of that address returns it.
- R3: Within the clock window, the offset from the window base selects the register. Offset 0 is control, and offsets 1 to 7 are seconds, minutes, hours, day, date, month and year. Time byte k is carried on bits [8k-1:8k-8] of live_time_i and load_time_o.
- R4: While control bits 7 and 6 are both clear, the shadow takes live_time_i at each clock edge where tick_i is high. It holds its value at edges where tick_i is low.
- R5: While control bit 6 (freeze) is set, the shadow ignores tick_i.
- R6: While control bit 7 (write-open) is set, write cycles to offsets 1 to 7 update the shadow and tick_i is ignored. While bit 7 is clear, such writes are ignored.
- R7: A control write that clears bit 7 while it is set makes load_o high for exactly the following cycle. In that cycle, load_time_o equals the shadow contents.
- R8: While pwr_ok_i is low, pwr_fail_o is high, no read is answered, and writes change neither memory nor registers.
- R9: After reset, control and shadow are zero, and dq_oe_o and load_o are low.
- R10: A read of the control register returns bit 7 (write-open), bit 6 (freeze) and zeros in bits 5 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| pwr_ok_i | input | 1 | Supply within tolerance |
| tick_i | input | 1 | Live counter update completed |
| live_time_i | input | 56 | Live time bytes from the calendar block |
| rdata_o | output | 8 | Read data, 0 when not driven |
| dq_oe_o | output | 1 | Data bus drive enable |
| pwr_fail_o | output | 1 | Supply out of tolerance |
| load_o | output | 1 | Load strobe to the calendar block |
| load_time_o | output | 56 | Time bytes to load |

## Verification
The assertions check several rules on every cycle. Read data is driven exactly one cycle after a qualified read and is zero at all other times. Nothing is answered or loaded during a power fault. The load strobe lasts a single cycle and always follows a control write. The bench scenarios cover the behaviour that depends on stored state. These include the shadow following, freezing and being opened for writing. They also include the committed time values, the control read-back layout, and memory contents surviving writes that were ignored during a power fault.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int NREG   = 8;
  localparam int NTIME  = NREG - 1;
  localparam int TW     = NTIME * 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int BIT_WO = 7;  // write-open
  localparam int BIT_FZ = 6;  // freeze
endpackage

// File: rtl/tk_decode.sv
module tk_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       ce_ni,
  input  logic                       oe_ni,
  input  logic                       we_ni,
  input  logic                       pwr_ok_i,
  output logic                       ram_we_o,
  output logic                       reg_we_o,
  output logic                       rd_o,
  output logic                       is_reg_o,
  output logic [tk_pkg::IDX_W-1:0]   idx_o
);
  import tk_pkg::*;
  logic sel;
  assign sel      = !ce_ni && pwr_ok_i;
  assign is_reg_o = &addr_i[ADDR_W-1:IDX_W];
  assign idx_o    = addr_i[IDX_W-1:0];
  assign ram_we_o = sel && !we_ni && !is_reg_o;
  assign reg_we_o = sel && !we_ni && is_reg_o;
  assign rd_o     = sel && !oe_ni && we_ni;
endmodule

// File: rtl/tk_ram.sv
module tk_ram #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];
  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/tk_shadow.sv
module tk_shadow (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [tk_pkg::IDX_W-1:0]  idx_i,
  input  logic [7:0]                wdata_i,
  input  logic                      tick_i,
  input  logic [tk_pkg::TW-1:0]     live_i,
  output logic [7:0]                rdata_o,
  output logic                      load_o,
  output logic [tk_pkg::TW-1:0]     load_time_o
);
  import tk_pkg::*;
  logic                wo_q, fz_q;
  logic [TW-1:0]       sh_q;
  logic                ctrl_we, refresh;

  assign ctrl_we = we_i && (idx_i == '0);
  assign refresh = tick_i && !wo_q && !fz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wo_q        <= 1'b0;
      fz_q        <= 1'b0;
      load_o      <= 1'b0;
      load_time_o <= '0;
    end else begin
      load_o <= ctrl_we && wo_q && !wdata_i[BIT_WO];
      if (ctrl_we && wo_q && !wdata_i[BIT_WO]) load_time_o <= sh_q;
      if (ctrl_we) begin
        wo_q <= wdata_i[BIT_WO];
        fz_q <= wdata_i[BIT_FZ];
      end
    end
  end

  for (genvar g = 1; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sh_q[8*g-1 -: 8] <= '0;
      else if (we_i && wo_q && (idx_i == IDX_W'(g)))
        sh_q[8*g-1 -: 8] <= wdata_i;
      else if (refresh)
        sh_q[8*g-1 -: 8] <= live_i[8*g-1 -: 8];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == '0) begin
      rdata_o[BIT_WO] = wo_q;
      rdata_o[BIT_FZ] = fz_q;
    end else begin
      rdata_o = sh_q[8*idx_i-1 -: 8];
    end
  end
endmodule

// File: rtl/tk_sram_rtc.sv
module tk_sram_rtc #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              pwr_ok_i,
  input  logic              tick_i,
  input  logic [55:0]       live_time_i,
  output logic [7:0]        rdata_o,
  output logic              dq_oe_o,
  output logic              pwr_fail_o,
  output logic              load_o,
  output logic [55:0]       load_time_o
);
  import tk_pkg::*;
  logic             ram_we, reg_we, rd, is_reg;
  logic [IDX_W-1:0] idx;
  logic [7:0]       ram_q, reg_d, reg_q;
  logic             rd_q, is_reg_q;

  tk_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i, .ce_ni, .oe_ni, .we_ni, .pwr_ok_i,
    .ram_we_o(ram_we), .reg_we_o(reg_we), .rd_o(rd),
    .is_reg_o(is_reg), .idx_o(idx)
  );

  tk_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i, .we_i(ram_we), .addr_i, .wdata_i, .rdata_o(ram_q)
  );

  tk_shadow u_shadow (
    .clk_i, .rst_ni, .we_i(reg_we), .idx_i(idx), .wdata_i,
    .tick_i, .live_i(live_time_i), .rdata_o(reg_d),
    .load_o, .load_time_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= 1'b0;
      is_reg_q <= 1'b0;
      reg_q    <= '0;
    end else begin
      rd_q     <= rd;
      is_reg_q <= is_reg;
      reg_q    <= reg_d;
    end
  end

  assign dq_oe_o    = rd_q;
  assign rdata_o    = !rd_q ? 8'h00 : (is_reg_q ? reg_q : ram_q);
  assign pwr_fail_o = !pwr_ok_i;
endmodule

// File: rtl/tk_sram_rtc_chk.sv
module tk_sram_rtc_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              pwr_ok_i,
  input logic [7:0]        rdata_o,
  input logic              dq_oe_o,
  input logic              load_o
);
  localparam logic [ADDR_W-1:0] BASE = {{(ADDR_W-3){1'b1}}, 3'b000};

  p_read_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && we_ni && pwr_ok_i) |=> dq_oe_o);
  p_no_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ce_ni && !oe_ni && we_ni && pwr_ok_i) |=> !dq_oe_o);
  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> rdata_o == 8'h00);
  p_pf_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !dq_oe_o && !load_o);
  p_load_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  p_load_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_o) |-> $past(!ce_ni && !we_ni && pwr_ok_i && addr_i == BASE && !wdata_i[7]));
endmodule

bind tk_sram_rtc tk_sram_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .addr_i, .wdata_i, .ce_ni, .oe_ni, .we_ni,
  .pwr_ok_i, .rdata_o, .dq_oe_o, .load_o
);

// File: tb/sim_tk_sram_rtc.sv
module sim_tk_sram_rtc;
  localparam int AW = 11;
  localparam logic [AW-1:0] BASE = {{(AW-3){1'b1}}, 3'b000};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, pwr_ok_i = 1'b1, tick_i = 1'b0;
  logic [55:0] live_time_i = '0;
  logic [7:0] rdata_o;
  logic dq_oe_o, pwr_fail_o, load_o;
  logic [55:0] load_time_o;
  int checks = 0, errors = 0;
  bit done = 0;

  tk_sram_rtc #(.ADDR_W(AW)) u0 (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; ce_ni = 0; we_ni = 0;
    @(negedge clk_i); ce_ni = 1; we_ni = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk_i); addr_i = a; ce_ni = 0; oe_ni = 0; we_ni = 1;
    @(negedge clk_i); d = rdata_o; v = dq_oe_o; ce_ni = 1; oe_ni = 1;
  endtask

  task automatic tick(input logic [55:0] t);
    @(negedge clk_i); live_time_i = t; tick_i = 1;
    @(negedge clk_i); tick_i = 0;
  endtask

  task automatic rd_time(output logic [55:0] t);
    logic [7:0] d; logic v;
    for (int k = 1; k < 8; k++) begin
      rd(BASE + AW'(k), d, v);
      t[8*k-1 -: 8] = d;
    end
  endtask

  task automatic t_reset;
    logic [55:0] t; logic [7:0] d; logic v;
    chk("R9 dq_oe", {63'd0, dq_oe_o}, 64'd0);
    chk("R9 load", {63'd0, load_o}, 64'd0);
    rd(BASE, d, v);
    chk("R9 ctrl", {56'd0, d}, 64'd0);
    rd_time(t);
    chk("R9 shadow", {8'd0, t}, 64'd0);
  endtask

  task automatic t_sram;
    logic [7:0] d; logic v;
    wr(AW'(5), 8'hA5); wr(AW'(BASE - 1), 8'h3C);
    rd(AW'(5), d, v);
    chk("R2 ram lo", {56'd0, d}, 64'hA5);
    chk("R1 drive", {63'd0, v}, 64'd1);
    rd(AW'(BASE - 1), d, v);
    chk("R2 ram top", {56'd0, d}, 64'h3C);
    @(negedge clk_i); addr_i = AW'(5); ce_ni = 0; oe_ni = 1; we_ni = 1;
    @(negedge clk_i);
    chk("R1 oe off", {55'd0, dq_oe_o, rdata_o}, 64'd0);
    ce_ni = 1;
  endtask

  task automatic t_refresh;
    logic [55:0] t;
    tick(56'h24_12_31_05_23_59_58);
    live_time_i = 56'h99_99_99_99_99_99_99;
    rd_time(t);
    chk("R4 R3 follow", {8'd0, t}, 64'h24_12_31_05_23_59_58);
  endtask

  task automatic t_freeze;
    logic [55:0] t; logic [7:0] d; logic v;
    wr(BASE, 8'h40);
    rd(BASE, d, v);
    chk("R10 ctrl fz", {56'd0, d}, 64'h40);
    tick(56'h25_01_01_06_00_00_00);
    rd_time(t);
    chk("R5 frozen", {8'd0, t}, 64'h24_12_31_05_23_59_58);
    wr(BASE, 8'h3F);
    rd(BASE, d, v);
    chk("R10 low bits", {56'd0, d}, 64'h00);
    tick(56'h25_01_01_06_00_00_01);
    rd_time(t);
    chk("R4 resumed", {8'd0, t}, 64'h25_01_01_06_00_00_01);
  endtask

  task automatic t_write_load;
    logic [55:0] t; logic [7:0] d; logic v;
    wr(BASE + AW'(1), 8'h11);
    rd(BASE + AW'(1), d, v);
    chk("R6 closed ignore", {56'd0, d}, 64'h01);
    wr(BASE, 8'h80);
    for (int k = 1; k < 8; k++) wr(BASE + AW'(k), 8'(8'h10 * k + k));
    tick(56'h00_00_00_00_00_00_00);
    rd_time(t);
    chk("R6 opened", {8'd0, t}, 64'h77_66_55_44_33_22_11);
    @(negedge clk_i); addr_i = BASE; wdata_i = 8'h00; ce_ni = 0; we_ni = 0;
    @(negedge clk_i); ce_ni = 1; we_ni = 1;
    chk("R7 load hi", {63'd0, load_o}, 64'd1);
    chk("R7 load data", {8'd0, load_time_o}, 64'h77_66_55_44_33_22_11);
    @(negedge clk_i);
    chk("R7 load lo", {63'd0, load_o}, 64'd0);
  endtask

  task automatic t_power;
    logic [7:0] d; logic v;
    @(negedge clk_i); pwr_ok_i = 0;
    #1 chk("R8 pf flag", {63'd0, pwr_fail_o}, 64'd1);
    wr(AW'(5), 8'h5A);
    wr(BASE, 8'h40);
    rd(AW'(5), d, v);
    chk("R8 no drive", {55'd0, v, d}, 64'd0);
    @(negedge clk_i); pwr_ok_i = 1;
    #1 chk("R8 pf clear", {63'd0, pwr_fail_o}, 64'd0);
    rd(AW'(5), d, v);
    chk("R8 ram kept", {56'd0, d}, 64'hA5);
    rd(BASE, d, v);
    chk("R8 ctrl kept", {56'd0, d}, 64'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset(); t_sram(); t_refresh(); t_freeze(); t_write_load(); t_power();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule